// File: doc/BRIEF.md
# Synchronous Cascaded Up/Down Digit Counter

This block is a wide binary counter built from a chain of identical 4-bit reversible digit stages that all share one clock. Each stage updates on the same clock edge as every other stage. A stage advances only when every stage below it sits at its terminal value and the global enable is active. A carry or borrow across any number of digits therefore completes in a single cycle, with no skew between the low and high digits.

One direction input selects counting up or counting down for all digits. An active-low load writes a full-width word into every digit at once and overrides counting. The block presents the whole count together with an overall terminal flag. In up mode the flag marks the all-ones value, and in down mode it marks zero. A surrounding design can use that flag to chain the counter further or to detect wrap.

Top module: `casc_updown_counter`

## Requirements
- R1: While `rst_n` is low the count is zero; after release it stays zero until a load or an enabled count.
- R2: When `load_n` is low at a rising clock edge, `count_q` equals `load_value` after that edge, whatever the values of `count_en_n` and `dir_down`.
- R3: With `load_n` high, `count_en_n` low and `dir_down` low (up), each rising edge adds one to the full-width count.
- R4: With `load_n` high, `count_en_n` low and `dir_down` high (down), each rising edge subtracts one from the full-width count.
- R5: With `load_n` high and `count_en_n` high, the count does not change at an edge, even when `dir_down` toggles.
- R6: Counting up from the all-ones value gives zero on the next edge.
- R7: Counting down from zero gives the all-ones value on the next edge.
- R8: `term_all` is combinational. It is 1 exactly when `dir_down` is 0 and the count is all ones, or when `dir_down` is 1 and the count is zero. It follows a change of `dir_down` without a clock edge.
- R9: A digit changes only in a cycle where every lower digit is at its terminal value (15 for up, 0 for down). A carry or borrow across several digits, for example 0x0FFF to 0x1000, completes in one edge.
- R10: `term_all` does not depend on `count_en_n`. It stays 1 at a terminal value while counting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all digit stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_n | input | 1 | Active-low synchronous parallel load for all digits |
| load_value | input | 4*NUM_STAGES | Word written into the counter on load |
| count_en_n | input | 1 | Active-low global count enable |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| count_q | output | 4*NUM_STAGES | Full count, digit 0 in the least significant bits |
| term_all | output | 1 | Overall terminal flag for the current direction |

## Verification
The clocked properties assume that `load_n`, `count_en_n`, `dir_down` and `load_value` are stable around the rising edge. The wrap and step properties compare against `$past`, so they also assume that the reset synchronizer has finished releasing before the first enabled cycle. The stimulus changes every input only on the falling clock edge. After releasing reset, it waits with the counter idle for several cycles before it issues the first load or count. The sequence preloads values next to each digit boundary and next to the full-width wrap points. This lets a small number of steps cover multi-digit carries and borrows in both directions.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  localparam int DIGIT_BITS = 4;
endpackage

// File: rtl/casc_rst_sync.sv
module casc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/casc_digit.sv
module casc_digit
  import casc_cnt_pkg::*;
#(
  parameter int DIGIT_W = DIGIT_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [DIGIT_W-1:0] load_val_i,
  input  logic               step_en_i,
  input  cnt_dir_e           dir_i,
  output logic [DIGIT_W-1:0] val_o,
  output logic               tc_o
);
  localparam logic [DIGIT_W-1:0] DIG_MAX = {DIGIT_W{1'b1}};
  localparam logic [DIGIT_W-1:0] DIG_ONE = {{(DIGIT_W-1){1'b0}}, 1'b1};

  logic [DIGIT_W-1:0] val_q;
  logic [DIGIT_W-1:0] val_d;
  logic               val_we;

  // Next-state logic: load wins over stepping.
  always_comb begin
    val_we = load_i | step_en_i;
    val_d  = val_q;
    if (load_i) begin
      val_d = load_val_i;
    end else if (step_en_i) begin
      if (dir_i == DIR_DOWN) begin
        val_d = val_q - DIG_ONE;
      end else begin
        val_d = val_q + DIG_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_we) begin
      val_q <= val_d;
    end
  end

  // Terminal flag depends on value and direction only, never on the enable.
  always_comb begin
    if (dir_i == DIR_DOWN) begin
      tc_o = (val_q == '0);
    end else begin
      tc_o = (val_q == DIG_MAX);
    end
  end

  assign val_o = val_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_o == $past(load_val_i)));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_en_i) |=> $stable(val_o));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_en_i && dir_i == DIR_UP) |=> (val_o == $past(val_o) + DIG_ONE));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_en_i && dir_i == DIR_DOWN) |=> (val_o == $past(val_o) - DIG_ONE));
endmodule

// File: rtl/casc_carry_chain.sv
module casc_carry_chain #(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic [NUM_STAGES-1:0] tc_i,
  output logic [NUM_STAGES-1:0] step_en_o,
  output logic                  tc_all_o
);
  // prefix[i] is the AND of run_i and the terminal flags of all digits below i.
  logic [NUM_STAGES:0] prefix;

  assign prefix[0] = run_i;

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_link
    assign step_en_o[gi]  = prefix[gi];
    assign prefix[gi + 1] = prefix[gi] & tc_i[gi];
  end

  assign tc_all_o = &tc_i;

  for (genvar gj = 1; gj < NUM_STAGES; gj++) begin : g_chk
    // R9: a higher digit is never enabled unless the digit below it is enabled and terminal.
    assert_carry_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_en_o[gj] |-> (step_en_o[gj-1] && tc_i[gj-1]));
  end
endmodule

// File: rtl/casc_updown_counter.sv
module casc_updown_counter
  import casc_cnt_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_n,
  input  logic [DIGIT_BITS*NUM_STAGES-1:0] load_value,
  input  logic                             count_en_n,
  input  logic                             dir_down,
  output logic [DIGIT_BITS*NUM_STAGES-1:0] count_q,
  output logic                             term_all
);
  localparam int CNT_W = DIGIT_BITS * NUM_STAGES;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic                  rst_int_n;
  logic [NUM_STAGES-1:0] tc_vec;
  logic [NUM_STAGES-1:0] en_vec;
  logic                  run;
  logic                  load;
  cnt_dir_e              dir;

  assign run  = ~count_en_n;
  assign load = ~load_n;
  assign dir  = dir_down ? DIR_DOWN : DIR_UP;

  casc_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  casc_carry_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (run),
    .tc_i      (tc_vec),
    .step_en_o (en_vec),
    .tc_all_o  (term_all)
  );

  for (genvar gs = 0; gs < NUM_STAGES; gs++) begin : g_digit
    casc_digit #(.DIGIT_W(DIGIT_BITS)) u_digit (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .load_i     (load),
      .load_val_i (load_value[gs*DIGIT_BITS +: DIGIT_BITS]),
      .step_en_i  (en_vec[gs]),
      .dir_i      (dir),
      .val_o      (count_q[gs*DIGIT_BITS +: DIGIT_BITS]),
      .tc_o       (tc_vec[gs])
    );
  end

  assert_term_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    term_all |-> (dir_down ? (count_q == '0) : (count_q == CNT_MAX)));

  assert_global_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_n && count_en_n) |=> $stable(count_q));

  assert_full_up_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_n && !count_en_n && !dir_down) |=> (count_q == $past(count_q) + CNT_ONE));

  assert_full_down_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_n && !count_en_n && dir_down) |=> (count_q == $past(count_q) - CNT_ONE));

  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_n && !count_en_n && !dir_down && count_q == CNT_MAX) |=> (count_q == '0));

  assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_n && !count_en_n && dir_down && count_q == '0) |=> (count_q == CNT_MAX));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_int_n |-> (count_q == '0));
endmodule

// File: tb/casc_updown_counter_test.sv
module casc_updown_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 4;
  localparam int W = 4 * STAGES;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         clk;
  logic         rst_n;
  logic         load_n;
  logic [W-1:0] load_value;
  logic         count_en_n;
  logic         dir_down;
  logic [W-1:0] count_q;
  logic         term_all;

  int compared;
  int mismatched;
  bit done;

  logic [W-1:0] ref_cnt;
  logic [W-1:0] exp_cnt_q[$];
  logic         exp_term_q[$];
  string        tag_q[$];

  casc_updown_counter #(.NUM_STAGES(STAGES)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .load_value (load_value),
    .count_en_n (count_en_n),
    .dir_down   (dir_down),
    .count_q    (count_q),
    .term_all   (term_all)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic term_of(logic [W-1:0] v, logic dn);
    return dn ? (v == '0) : (v == ALL1);
  endfunction

  task automatic check_now(string tag, logic [W-1:0] ec, logic et);
    compared++;
    if (count_q !== ec || term_all !== et) begin
      mismatched++;
      $display("FAIL %s: count=%h term=%b expected count=%h term=%b", tag, count_q, term_all, ec, et);
    end
  endtask

  // Driver: applies one cycle of stimulus on the falling edge and queues the expected result.
  task automatic step(logic ld_n, logic en_n, logic dn, logic [W-1:0] data, string tag);
    @(negedge clk);
    load_n     = ld_n;
    count_en_n = en_n;
    dir_down   = dn;
    load_value = data;
    if (!ld_n) ref_cnt = data;
    else if (!en_n) ref_cnt = dn ? ref_cnt - 1'b1 : ref_cnt + 1'b1;
    exp_cnt_q.push_back(ref_cnt);
    exp_term_q.push_back(term_of(ref_cnt, dn));
    tag_q.push_back(tag);
  endtask

  // Monitor: samples just after each rising edge and compares with the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_cnt_q.size() > 0) begin
        check_now(tag_q.pop_front(), exp_cnt_q.pop_front(), exp_term_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected finish");
    finish_run();
  end

  initial begin
    compared = 0;
    mismatched = 0;
    done = 1'b0;
    ref_cnt = '0;
    rst_n = 1'b0;
    load_n = 1'b0;
    count_en_n = 1'b0;
    dir_down = 1'b0;
    load_value = 16'h5A5A;
    repeat (3) @(negedge clk);
    check_now("R1 in reset (load held active)", '0, 1'b0);
    load_n = 1'b1;
    count_en_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now("R1 after release", '0, 1'b0);

    step(1'b0, 1'b0, 1'b1, 16'h0FFD, "R2 load over enable");
    step(1'b1, 1'b0, 1'b0, '0, "R3 up");
    step(1'b1, 1'b0, 1'b0, '0, "R3 up to 0FFF");
    step(1'b1, 1'b0, 1'b0, '0, "R9 carry 0FFF to 1000");
    step(1'b1, 1'b0, 1'b0, '0, "R3 up after carry");
    step(1'b1, 1'b1, 1'b1, 16'hFFFF, "R5 hold dir down");
    step(1'b1, 1'b1, 1'b0, 16'h0000, "R5 hold dir up");
    step(1'b1, 1'b1, 1'b1, 16'h1234, "R5 hold toggled");
    step(1'b0, 1'b1, 1'b0, 16'hFFFE, "R2 load with enable off");
    step(1'b1, 1'b0, 1'b0, '0, "R8 term at all ones up");
    step(1'b1, 1'b0, 1'b0, '0, "R6 wrap up");
    step(1'b1, 1'b0, 1'b1, '0, "R7 wrap down");
    step(1'b1, 1'b0, 1'b1, '0, "R4 down");
    step(1'b0, 1'b0, 1'b1, 16'h0001, "R2 load 0001");
    step(1'b1, 1'b0, 1'b1, '0, "R8 term at zero down");
    step(1'b1, 1'b1, 1'b0, '0, "R8 term drops when dir up at zero");
    step(1'b0, 1'b1, 1'b0, 16'hFFFF, "R2 load FFFF");
    step(1'b1, 1'b1, 1'b0, '0, "R10 term with enable off");
    step(1'b1, 1'b1, 1'b1, '0, "R10 no term at FFFF down");
    step(1'b0, 1'b1, 1'b1, 16'h1000, "R2 load 1000");
    step(1'b1, 1'b0, 1'b1, '0, "R9 borrow 1000 to 0FFF");
    step(1'b1, 1'b0, 1'b1, '0, "R4 down after borrow");
    step(1'b0, 1'b0, 1'b0, 16'h00F0, "R2 load 00F0");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, '0, "R3 up run across digit");
    for (int i = 0; i < 40; i++) step(1'b1, (i % 5) == 2, 1'b1, '0, "R4 down run with holds R5");
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, i[0], '0, "R3 R4 alternating direction");
    step(1'b0, 1'b0, 1'b0, 16'hFFF0, "R2 load FFF0");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, '0, "R6 up through wrap");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule